// File: doc/BRIEF.md
# DDR Parallel-to-Serial Output Serializer

This block turns a parallel word into a single serial bit stream. A word of 4 or 8 bits is taken on each rising edge of a divided clock. It is shifted out on both phases of a fast clock, one bit per half cycle, with bit 0 going first. The divided clock runs at exactly WIDTH/2 fast cycles per period, and its rising edges line up with fast rising edges. The block has a fixed latency that depends on the width. Because of that latency, consecutive words leave the block as one continuous stream with no gaps.

Single-data-rate ratios are built from the same DDR machinery. The caller repeats each bit on two adjacent inputs, so every bit fills a whole fast cycle. A 3-state control output runs beside the data path. It can follow the fabric 3-state input directly. It can also be captured together with each word and switched in step with that word's first serial bit. A data bypass sends input bit 0 straight to the serial pin. Parameters set the value every data flop holds in reset, and they can invert the reset and both clocks.

Top module: `ddr_serializer`

## Requirements
- R1: On each divided-clock rising edge, bits [WIDTH-1:0] of `par_in` are captured. Bit 0 goes out first. Bit 2k is driven while the fast clock is high and bit 2k+1 while it is low, during the k-th fast cycle of the word.
- R2: Call the fast cycle that starts at the capture edge cycle 0. The first bit appears in fast cycle 3 when WIDTH is 8 and in fast cycle 1 when WIDTH is 4.
- R3: Words captured on consecutive divided-clock edges come out back to back. Each word fills exactly WIDTH/2 fast cycles, with no idle half cycle between words.
- R4: With WIDTH 4, `par_in[7:4]` has no effect on `ser_out`.
- R5: SDR 4:1 at WIDTH 8 and SDR 2:1 at WIDTH 4 work by repeating each input bit on two adjacent lines. Each bit then stays on `ser_out` for both phases of one fast cycle.
- R6: While reset is active, `ser_out` equals INIT_VAL and, without the 3-state bypass, `t_out` is 1 (tri-stated). This holds whatever `par_in` and `t_in` carry.
- R7: Without the 3-state bypass, `t_in` is captured on the same divided-clock edge as its word. `t_out` takes that value in the fast cycle of the word's first bit and keeps it until the next word starts.
- R8: With TRI_BYPASS set, `t_out` follows `t_in` combinationally (1 = tri-state, 0 = drive).
- R9: With DATA_BYPASS set, `ser_out` follows `par_in[0]` combinationally.
- R10: With RST_INV set, the reset input is active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast bit clock; serial data changes on both of its edges |
| clk_div | input | 1 | Divided word clock, WIDTH/2 fast cycles per period, rising edges aligned with fast rising edges |
| rst | input | 1 | Reset, asserted asynchronously, released synchronously inside each domain |
| par_in | input | 8 | Parallel word; only bits [WIDTH-1:0] are used |
| t_in | input | 1 | 3-state request from fabric logic (1 = tri-state) |
| ser_out | output | 1 | Serial data stream |
| t_out | output | 1 | 3-state control toward the pad |

## Verification
Every serial bit is placed at a known half-cycle, so almost any wrong internal state shows on `ser_out` within one word period. A stuck or late load mark shifts the whole word by whole fast cycles, or repeats filler bits, at the first expected bit. A wrong bit order or wrong phase swaps neighbouring bits inside that same fast cycle. Corrupt 3-state capture shows on `t_out` at the first bit of the affected word. A word-period checker flags a load mark that arrives off its WIDTH/2 grid at the very next load.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;
   localparam int PIN_W = 8;

   // fast cycles from the capture edge to the first serial bit
   function automatic int word_latency(input int width);
      return (width == 8) ? 3 : 1;
   endfunction

   // fast cycles occupied by one word
   function automatic int word_cycles(input int width);
      return width / 2;
   endfunction
endpackage

// File: rtl/ddrser_rst_sync.sv
module ddrser_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain_q <= '0;
      else      chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ddrser_capture.sv
module ddrser_capture #(
   parameter int WIDTH    = 8,
   parameter bit INIT_VAL = 1'b0
) (
   input  logic             clk_d,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             t_in,
   output logic [WIDTH-1:0] word_q,
   output logic             t_word_q
);
   always_ff @(posedge clk_d or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= {WIDTH{INIT_VAL}};
         t_word_q <= 1'b1;
      end else begin
         word_q   <= par_in;
         t_word_q <= t_in;
      end
   end
endmodule

// File: rtl/ddrser_load_gen.sv
module ddrser_load_gen
   import ddrser_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic clk_f,
   input  logic arst,
   input  logic rst_n_p,
   input  logic clk_d,
   output logic load_now
);
   localparam int PIPE = word_latency(WIDTH) - 1;

   logic clk_fn;
   logic rst_n_n;
   logic div_s, div_prev, rise;

   assign clk_fn = ~clk_f;

   ddrser_rst_sync #(.STAGES(2)) u_rs_neg (
      .clk   (clk_fn),
      .arst  (arst),
      .rst_n (rst_n_n)
   );

   // the word clock is sampled mid-cycle, away from both of its edges
   always_ff @(negedge clk_f or negedge rst_n_n) begin
      if (!rst_n_n) begin
         div_s    <= 1'b1;
         div_prev <= 1'b1;
      end else begin
         div_s    <= clk_d;
         div_prev <= div_s;
      end
   end

   assign rise = div_s & ~div_prev;

   generate
      if (PIPE == 0) begin : g_direct
         assign load_now = rise;
      end else begin : g_delay
         logic [PIPE-1:0] dly_q;
         always_ff @(posedge clk_f or negedge rst_n_p) begin
            if (!rst_n_p) dly_q <= '0;
            else begin
               dly_q[0] <= rise;
               for (int i = 1; i < PIPE; i++) dly_q[i] <= dly_q[i-1];
            end
         end
         assign load_now = dly_q[PIPE-1];
      end
   endgenerate
endmodule

// File: rtl/ddrser_shift.sv
module ddrser_shift #(
   parameter int WIDTH    = 8,
   parameter bit INIT_VAL = 1'b0
) (
   input  logic             clk_f,
   input  logic             rst_n,
   input  logic             load_now,
   input  logic [WIDTH-1:0] word_in,
   input  logic             t_word,
   output logic [1:0]       pair_q,
   output logic             t_q
);
   localparam int SHW = WIDTH - 2;

   logic [SHW-1:0] rest_q, rest_next;

   generate
      if (SHW == 2) begin : g_short
         assign rest_next = {2{INIT_VAL}};
      end else begin : g_long
         assign rest_next = {{2{INIT_VAL}}, rest_q[SHW-1:2]};
      end
   endgenerate

   always_ff @(posedge clk_f or negedge rst_n) begin
      if (!rst_n) begin
         pair_q <= {2{INIT_VAL}};
         rest_q <= {SHW{INIT_VAL}};
         t_q    <= 1'b1;
      end else if (load_now) begin
         pair_q <= word_in[1:0];
         rest_q <= word_in[WIDTH-1:2];
         t_q    <= t_word;
      end else begin
         pair_q <= rest_q[1:0];
         rest_q <= rest_next;
      end
   end
endmodule

// File: rtl/ddr_serializer.sv
module ddr_serializer
   import ddrser_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit INIT_VAL    = 1'b0,
   parameter bit DATA_BYPASS = 1'b0,
   parameter bit TRI_BYPASS  = 1'b0,
   parameter bit CLK_INV     = 1'b0,
   parameter bit DIV_INV     = 1'b0,
   parameter bit RST_INV     = 1'b0
) (
   input  logic             clk_fast,
   input  logic             clk_div,
   input  logic             rst,
   input  logic [PIN_W-1:0] par_in,
   input  logic             t_in,
   output logic             ser_out,
   output logic             t_out
);
   generate
      if (WIDTH != 4 && WIDTH != 8) begin : g_bad_width
         $error("ddr_serializer: WIDTH must be 4 or 8");
      end
   endgenerate

   logic             clk_f, clk_d, rst_act;
   logic             rst_n_d, rst_n_p;
   logic [WIDTH-1:0] word_q;
   logic             t_word_q;
   logic             load_now;
   logic [1:0]       pair_q;
   logic             t_q;
   logic             ser_path;

   assign clk_f   = clk_fast ^ CLK_INV;
   assign clk_d   = clk_div ^ DIV_INV;
   assign rst_act = rst ^ RST_INV;

   ddrser_rst_sync #(.STAGES(2)) u_rs_div (
      .clk(clk_d), .arst(rst_act), .rst_n(rst_n_d)
   );

   ddrser_rst_sync #(.STAGES(2)) u_rs_fast (
      .clk(clk_f), .arst(rst_act), .rst_n(rst_n_p)
   );

   ddrser_capture #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_capture (
      .clk_d    (clk_d),
      .rst_n    (rst_n_d),
      .par_in   (par_in[WIDTH-1:0]),
      .t_in     (t_in),
      .word_q   (word_q),
      .t_word_q (t_word_q)
   );

   ddrser_load_gen #(.WIDTH(WIDTH)) u_load_gen (
      .clk_f    (clk_f),
      .arst     (rst_act),
      .rst_n_p  (rst_n_p),
      .clk_d    (clk_d),
      .load_now (load_now)
   );

   ddrser_shift #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_shift (
      .clk_f    (clk_f),
      .rst_n    (rst_n_p),
      .load_now (load_now),
      .word_in  (word_q),
      .t_word   (t_word_q),
      .pair_q   (pair_q),
      .t_q      (t_q)
   );

   // high phase shows the earlier bit of the pair, low phase the later one
   assign ser_path = clk_f ? pair_q[0] : pair_q[1];

   generate
      if (DATA_BYPASS) begin : g_data_byp
         assign ser_out = par_in[0];
      end else begin : g_data_ser
         assign ser_out = ser_path;
      end
      if (TRI_BYPASS) begin : g_tri_byp
         assign t_out = t_in;
      end else begin : g_tri_ser
         assign t_out = t_q;
      end
   endgenerate
endmodule

// File: rtl/ddrser_chk.sv
module ddrser_chk #(
   parameter int WIDTH       = 8,
   parameter bit INIT_VAL    = 1'b0,
   parameter bit DATA_BYPASS = 1'b0,
   parameter bit TRI_BYPASS  = 1'b0
) (
   input logic       clk_f,
   input logic       rst_act,
   input logic       load_now,
   input logic [7:0] par_in,
   input logic       t_in,
   input logic       ser_out,
   input logic       t_out
);
   localparam int HALF = WIDTH / 2;

   int unsigned gap;
   logic        seen;

   always_ff @(posedge clk_f or posedge rst_act) begin
      if (rst_act) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (load_now) begin
         gap  <= 0;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   AST_LOAD_PERIOD: assert property (@(posedge clk_f) disable iff (rst_act)
      (load_now && seen) |-> (gap == HALF - 1)); // R3

   generate
      if (!TRI_BYPASS) begin : g_tri_hold
         AST_TRI_HOLD: assert property (@(posedge clk_f) disable iff (rst_act)
            !load_now |=> $stable(t_out)); // R7
      end
   endgenerate

   always @(negedge clk_f) begin
      if (rst_act === 1'b1 && !DATA_BYPASS) begin
         AST_RST_INIT: assert (ser_out === INIT_VAL); // R6
      end
      if (DATA_BYPASS) begin
         AST_DATA_BYPASS: assert (ser_out === par_in[0]); // R9
      end
      if (TRI_BYPASS) begin
         AST_TRI_BYPASS: assert (t_out === t_in); // R8
      end
   end
endmodule

bind ddr_serializer ddrser_chk #(
   .WIDTH       (WIDTH),
   .INIT_VAL    (INIT_VAL),
   .DATA_BYPASS (DATA_BYPASS),
   .TRI_BYPASS  (TRI_BYPASS)
) u_chk (
   .clk_f    (clk_f),
   .rst_act  (rst_act),
   .load_now (load_now),
   .par_in   (par_in),
   .t_in     (t_in),
   .ser_out  (ser_out),
   .t_out    (t_out)
);

// File: tb/test_ddr_serializer.sv
module test_ddr_serializer;
   localparam int CLK_PERIOD = 10;

   logic       clk_fast = 1'b0;
   logic       div8 = 1'b0;
   logic       div4 = 1'b0;
   int         cyc = 0;
   logic       rst, rst4;
   logic [7:0] par8, par4, parB;
   logic       t8, t4, tB;
   logic       ser8, ser4, serB;
   logic       tout8, tout4, toutB;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   typedef struct {
      int    cyc;
      bit    ph;
      bit    d;
      bit    t;
      bit    chk_t;
      string req;
   } exp_t;

   exp_t q8[$];
   exp_t q4[$];

   ddr_serializer i_ddr_serializer (
      .clk_fast(clk_fast), .clk_div(div8), .rst(rst), .par_in(par8),
      .t_in(t8), .ser_out(ser8), .t_out(tout8)
   );

   ddr_serializer #(.WIDTH(4), .INIT_VAL(1'b1), .TRI_BYPASS(1'b1), .RST_INV(1'b1))
   i_ddr_serializer_w4 (
      .clk_fast(clk_fast), .clk_div(div4), .rst(rst4), .par_in(par4),
      .t_in(t4), .ser_out(ser4), .t_out(tout4)
   );

   ddr_serializer #(.DATA_BYPASS(1'b1)) i_ddr_serializer_byp (
      .clk_fast(clk_fast), .clk_div(div8), .rst(rst), .par_in(parB),
      .t_in(tB), .ser_out(serB), .t_out(toutB)
   );

   // clocks: word clocks rise together with fast rising edges
   initial begin
      #2;
      forever begin
         #(CLK_PERIOD/2);
         cyc = cyc + 1;
         clk_fast = 1'b1;
         if (cyc % 4 == 0) div8 = 1'b1;
         else if (cyc % 4 == 2) div8 = 1'b0;
         div4 = (cyc % 2 == 0);
         #(CLK_PERIOD/2);
         clk_fast = 1'b0;
      end
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic scan(input bit ph);
      exp_t e;
      if (q8.size() > 0 && q8[0].cyc == cyc && q8[0].ph == ph) begin
         e = q8.pop_front();
         check(e.req, ser8, e.d, "w8 serial bit");
         if (e.chk_t) check("R7", tout8, e.t, "w8 tristate");
      end
      if (q4.size() > 0 && q4[0].cyc == cyc && q4[0].ph == ph) begin
         e = q4.pop_front();
         check(e.req, ser4, e.d, "w4 serial bit");
      end
   endtask

   // monitor: one sample in each phase of every fast cycle
   initial begin
      forever begin
         @(posedge clk_fast);
         #(CLK_PERIOD/4);
         scan(1'b0);
         #(CLK_PERIOD/2);
         scan(1'b1);
      end
   end

   // width 8: capture on the next word edge, first bit 3 cycles later
   task automatic send8(input logic [7:0] word, input logic t, input string req);
      int c0;
      exp_t e;
      @(posedge div8);
      #1;
      par8 = word;
      t8   = t;
      c0   = cyc;
      for (int i = 0; i < 8; i++) begin
         e.cyc = c0 + 4 + 3 + i / 2;
         e.ph = i[0];
         e.d = word[i];
         e.t = t;
         e.chk_t = 1'b1;
         e.req = req;
         q8.push_back(e);
      end
   endtask

   // width 4: capture on the next word edge, first bit 1 cycle later
   task automatic send4(input logic [7:0] word, input string req);
      int c0;
      exp_t e;
      @(posedge div4);
      #1;
      par4 = word;
      c0   = cyc;
      for (int i = 0; i < 4; i++) begin
         e.cyc = c0 + 2 + 1 + i / 2;
         e.ph = i[0];
         e.d = word[i];
         e.t = 1'b0;
         e.chk_t = 1'b0;
         e.req = req;
         q4.push_back(e);
      end
   endtask

   initial begin
      rst = 1'b0; rst4 = 1'b1;
      par8 = 8'hFF; par4 = 8'hA5; parB = 8'h00;
      t8 = 1'b0; t4 = 1'b0; tB = 1'b0;
      #1;
      rst = 1'b1; rst4 = 1'b0;

      // R6 / R10: reset state with busy inputs
      repeat (5) @(posedge clk_fast);
      #(CLK_PERIOD/4);
      check("R6", ser8, 1'b0, "reset high phase");
      check("R6", tout8, 1'b1, "reset tristate");
      check("R10", ser4, 1'b1, "active-low reset high phase");
      #(CLK_PERIOD/2);
      check("R6", ser8, 1'b0, "reset low phase");
      check("R10", ser4, 1'b1, "active-low reset low phase");

      @(posedge clk_fast);
      #(CLK_PERIOD/4);
      rst = 1'b0; rst4 = 1'b1;
      repeat (20) @(posedge clk_fast);

      // width 8 stream, back to back
      send8(8'h96, 1'b0, "R1");
      send8(8'h01, 1'b1, "R2");
      send8(8'hFE, 1'b0, "R3");
      send8(8'h80, 1'b1, "R3");
      send8(8'hCF, 1'b0, "R5");   // SDR 4:1, nibble 1011 duplicated
      send8(8'h5A, 1'b1, "R1");

      // width 4 stream, upper bits must be ignored
      send4(8'hF5, "R4");
      send4(8'h0A, "R2");
      send4(8'h3C, "R4");
      send4(8'h03, "R5");         // SDR 2:1, D0=1 D1=0 duplicated
      send4(8'h96, "R3");

      repeat (12) @(posedge clk_fast);
      #1;
      checks++;
      if (q8.size() != 0 || q4.size() != 0) begin
         errors++;
         $display("FAIL R3 stream drain: actual=%0d/%0d expected=0/0", q8.size(), q4.size());
      end

      // R9: data bypass
      @(posedge clk_fast);
      #1; parB = 8'h01;
      #1; check("R9", serB, 1'b1, "data bypass bit0=1");
      parB = 8'hFE;
      #1; check("R9", serB, 1'b0, "data bypass bit0=0");

      // R8: 3-state bypass
      @(posedge clk_fast);
      #1; t4 = 1'b1;
      #1; check("R8", tout4, 1'b1, "tristate bypass high");
      t4 = 1'b0;
      #1; check("R8", tout4, 1'b0, "tristate bypass low");

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule